// File: doc/BRIEF.md
# Controlled-Clock Stall Generator

This block sits on a free-running reference clock and produces three derived clocks whose progress can be halted by the test environment: a fast clock whose rising edge is its active edge, a second fast clock whose falling edge is its active edge, and a slow clock with an even duty cycle. Each active or inactive transition of the derived clocks happens on a reference-clock rising edge, and only on edges where every one of four readiness inputs is high. A single low readiness input holds every derived clock where it is, so no derived clock can drift ahead of another.

Alongside the clocks the block drives four single-cycle strobes, one per edge kind: fast rise, fast fall, slow rise and slow fall. Logic that runs on the reference clock qualifies its registers with these strobes instead of clocking on the derived clocks. The slow clock's half period is a parameter counted in fast-clock rising edges. Its counter only advances on cycles that are not held, so the even duty cycle holds in derived time however the holds fall.

Top module: `ctrl_clk_stall_gen`

## Requirements
- R1: While `rst` is high at a reference rising edge, all three derived clocks and all four strobes are low in the following cycle.
- R2: With all readiness inputs high, `fast_clk` changes level at every reference rising edge. The first change after `rst` is released is `fast_clk` going from 0 to 1.
- R3: `fast_neg_clk` has its active falling edge at every second advancing step, on the step where `fast_clk` falls. Its inactive rise happens together with the rise of `fast_clk`.
- R4: `slow_clk` changes level only at steps where `fast_clk` rises. It rises on the first such step after reset, then stays high for `SLOW_HALF` fast rising edges and low for `SLOW_HALF` fast rising edges, repeating.
- R5: Each strobe is high for exactly the one cycle in which its derived clock first shows the new level. `en_fast_rise` goes with `fast_clk` 0 to 1, `en_fast_fall` with `fast_neg_clk` 1 to 0, `en_slow_rise` with `slow_clk` 0 to 1, and `en_slow_fall` with `slow_clk` 1 to 0.
- R6: If any of `rdy_fast_rise`, `rdy_fast_fall`, `rdy_slow_rise`, `rdy_slow_fall` is low at a reference rising edge, no derived clock changes at that edge and all strobes are low in the next cycle.
- R7: At the first reference rising edge where all readiness inputs are high again, the sequence continues from the exact point where it stopped.
- R8: Measured only over advancing steps, `slow_clk` stays high for exactly 2*`SLOW_HALF` steps per period, whatever holds are inserted.
- R9: `en_fast_rise` and `en_fast_fall` are never high together, and a slow strobe is high only in a cycle where `en_fast_rise` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_fast_rise | input | 1 | Readiness for fast rising edges; low holds all clocks |
| rdy_fast_fall | input | 1 | Readiness for fast falling edges; low holds all clocks |
| rdy_slow_rise | input | 1 | Readiness for slow rising edges; low holds all clocks |
| rdy_slow_fall | input | 1 | Readiness for slow falling edges; low holds all clocks |
| fast_clk | output | 1 | Fast derived clock, rising edge active |
| fast_neg_clk | output | 1 | Fast derived clock, falling edge active |
| slow_clk | output | 1 | Slow derived clock, even duty cycle |
| en_fast_rise | output | 1 | Strobe for a fast rising edge |
| en_fast_fall | output | 1 | Strobe for a fast falling edge |
| en_slow_rise | output | 1 | Strobe for a slow rising edge |
| en_slow_fall | output | 1 | Strobe for a slow falling edge |

## Verification
The bench drops each readiness input on its own, at a fast-rise step, at a fast-fall step and just before a slow-clock edge. A design that froze only the matching clock would let the others move, and one that lost a step would come back on the wrong phase. Long runs of random holds across several slow periods catch a slow counter that keeps running through held cycles: its duty cycle, measured in advancing steps, would drift from an even split. A reset in mid-sequence and the first edge after it catch a design that starts on a falling phase or keeps a strobe high.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  localparam int unsigned NUM_READY = 4;

  typedef struct packed {
    logic fast_rise;
    logic fast_fall;
    logic slow_rise;
    logic slow_fall;
  } ccg_edges_t;
endpackage

// File: rtl/ccg_freeze.sv
module ccg_freeze
  import ccg_pkg::*;
#(
  parameter int unsigned N = NUM_READY
) (
  input  logic [N-1:0] ready,
  output logic         advance
);
  // Any single low input stops every derived clock together.
  always_comb begin
    advance = 1'b1;
    for (int i = 0; i < N; i++) begin
      advance = advance & ready[i];
    end
  end
endmodule

// File: rtl/ccg_fast_seq.sv
module ccg_fast_seq (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic fast_q,
  output logic fast_neg_q,
  output logic rise_step,
  output logic fall_step
);
  // fast_q doubles as the phase bit: low means the next step is a rise.
  assign rise_step = advance & ~fast_q;
  assign fall_step = advance &  fast_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q     <= 1'b0;
      fast_neg_q <= 1'b0;
    end else if (advance) begin
      fast_q     <= ~fast_q;
      fast_neg_q <= ~fast_q;
    end
  end
endmodule

// File: rtl/ccg_slow_div.sv
module ccg_slow_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic slow_q,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          flip;

  // Slow edges land on the fast rise that starts each half period.
  assign flip     = tick & (cnt_q == '0);
  assign rise_evt = flip & ~slow_q;
  assign fall_evt = flip &  slow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      if (flip) slow_q <= ~slow_q;
    end
  end
endmodule

// File: rtl/ctrl_clk_stall_gen.sv
module ctrl_clk_stall_gen
  import ccg_pkg::*;
#(
  parameter int unsigned SLOW_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_fast_rise,
  input  logic rdy_fast_fall,
  input  logic rdy_slow_rise,
  input  logic rdy_slow_fall,
  output logic fast_clk,
  output logic fast_neg_clk,
  output logic slow_clk,
  output logic en_fast_rise,
  output logic en_fast_fall,
  output logic en_slow_rise,
  output logic en_slow_fall
);
  logic             advance;
  logic             rise_step;
  logic             fall_step;
  logic             s_rise;
  logic             s_fall;
  ccg_edges_t       evt_d;
  ccg_edges_t       evt_q;

  ccg_freeze #(.N(NUM_READY)) u_freeze (
    .ready   ({rdy_slow_fall, rdy_slow_rise, rdy_fast_fall, rdy_fast_rise}),
    .advance (advance)
  );

  ccg_fast_seq u_fast (
    .clk        (clk),
    .rst        (rst),
    .advance    (advance),
    .fast_q     (fast_clk),
    .fast_neg_q (fast_neg_clk),
    .rise_step  (rise_step),
    .fall_step  (fall_step)
  );

  ccg_slow_div #(.HALF(SLOW_HALF)) u_slow (
    .clk      (clk),
    .rst      (rst),
    .tick     (rise_step),
    .slow_q   (slow_clk),
    .rise_evt (s_rise),
    .fall_evt (s_fall)
  );

  always_comb begin
    evt_d.fast_rise = rise_step;
    evt_d.fast_fall = fall_step;
    evt_d.slow_rise = s_rise;
    evt_d.slow_fall = s_fall;
  end

  // Strobes are registered alongside the clock registers.
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  assign en_fast_rise = evt_q.fast_rise;
  assign en_fast_fall = evt_q.fast_fall;
  assign en_slow_rise = evt_q.slow_rise;
  assign en_slow_fall = evt_q.slow_fall;
endmodule

// File: rtl/ccg_stall_chk.sv
module ccg_stall_chk (
  input logic clk,
  input logic rst,
  input logic rdy_fast_rise,
  input logic rdy_fast_fall,
  input logic rdy_slow_rise,
  input logic rdy_slow_fall,
  input logic fast_clk,
  input logic fast_neg_clk,
  input logic slow_clk,
  input logic en_fast_rise,
  input logic en_fast_fall,
  input logic en_slow_rise,
  input logic en_slow_fall
);
  logic all_rdy;
  assign all_rdy = rdy_fast_rise & rdy_fast_fall & rdy_slow_rise & rdy_slow_fall;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ({fast_clk, fast_neg_clk, slow_clk, en_fast_rise, en_fast_fall,
              en_slow_rise, en_slow_fall} == 7'b0));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !all_rdy |=> $stable({fast_clk, fast_neg_clk, slow_clk}));

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !all_rdy |=> ({en_fast_rise, en_fast_fall, en_slow_rise, en_slow_fall} == 4'b0));

  // R2
  run_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    all_rdy |=> (fast_clk != $past(fast_clk)));

  // R5
  rise_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    en_fast_rise |-> (fast_clk && !$past(fast_clk)));

  // R5
  slow_fall_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    en_slow_fall |-> (!slow_clk && $past(slow_clk)));

  // R9
  fast_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_fast_rise, en_fast_fall}));

  // R9
  slow_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (en_slow_rise || en_slow_fall) |-> en_fast_rise);

  // R3
  neg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    en_fast_fall |-> (!fast_neg_clk && $past(fast_neg_clk)));
endmodule

bind ctrl_clk_stall_gen ccg_stall_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .rdy_fast_rise (rdy_fast_rise),
  .rdy_fast_fall (rdy_fast_fall),
  .rdy_slow_rise (rdy_slow_rise),
  .rdy_slow_fall (rdy_slow_fall),
  .fast_clk      (fast_clk),
  .fast_neg_clk  (fast_neg_clk),
  .slow_clk      (slow_clk),
  .en_fast_rise  (en_fast_rise),
  .en_fast_fall  (en_fast_fall),
  .en_slow_rise  (en_slow_rise),
  .en_slow_fall  (en_slow_fall)
);

// File: tb/ctrl_clk_stall_gen_test.sv
module ctrl_clk_stall_gen_test;
  localparam int PERIOD = 10;
  localparam int HALF   = 4;
  localparam int LIMIT  = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] rdy = 4'hF;  // {slow_fall, slow_rise, fast_fall, fast_rise}
  logic fc, fnc, sc, efr, eff, esr, esf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [6:0] val;   // {fast, fast_neg, slow, en_fr, en_ff, en_sr, en_sf}
    string      tag;
  } item_t;
  item_t q[$];

  // Requirement-level model state
  logic m_fast = 0;
  logic m_slow = 0;
  int   m_cnt  = 0;
  bit   m_held = 0;

  always #(PERIOD/2) clk = ~clk;

  ctrl_clk_stall_gen #(.SLOW_HALF(HALF)) uut (
    .clk(clk), .rst(rst),
    .rdy_fast_rise(rdy[0]), .rdy_fast_fall(rdy[1]),
    .rdy_slow_rise(rdy[2]), .rdy_slow_fall(rdy[3]),
    .fast_clk(fc), .fast_neg_clk(fnc), .slow_clk(sc),
    .en_fast_rise(efr), .en_fast_fall(eff),
    .en_slow_rise(esr), .en_slow_fall(esf)
  );

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one reference cycle, pushes the expected outputs after the edge.
  task automatic step(input logic r, input logic [3:0] ready);
    item_t it;
    logic fr = 0, ff = 0, sr = 0, sf = 0;
    @(negedge clk);
    rst = r;
    rdy = ready;
    if (r) begin
      m_fast = 0; m_slow = 0; m_cnt = 0; m_held = 0;
      it.tag = "R1";
    end else if (ready != 4'hF) begin
      it.tag = "R6";
      m_held = 1;
    end else begin
      it.tag = m_held ? "R7" : (m_fast ? "R3" : "R2");
      m_held = 0;
      if (!m_fast) begin
        fr = 1;
        if (m_cnt == 0) begin
          if (m_slow) sf = 1; else sr = 1;
          m_slow = ~m_slow;
          if (it.tag != "R7") it.tag = "R4";
        end
        m_cnt = (m_cnt == HALF-1) ? 0 : m_cnt + 1;
      end else begin
        ff = 1;
      end
      m_fast = ~m_fast;
    end
    it.val = {m_fast, m_fast, m_slow, fr, ff, sr, sf};
    q.push_back(it);
  endtask

  // Monitor: compares just after each edge, away from the driver's negedge.
  logic p_fc = 0, p_fnc = 0, p_sc = 0;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(it.tag, {fc, fnc, sc, efr, eff, esr, esf}, it.val);
        if (!rst) begin
          check("R5", {efr, eff, esr, esf},
                {fc & ~p_fc, ~fnc & p_fnc, sc & ~p_sc, ~sc & p_sc});
          check("R9", {1'b0, efr & eff, (esr | esf) & ~efr}, 3'b0);
        end
      end
      p_fc = fc; p_fnc = fnc; p_sc = sc;
    end
  end

  // R8: duty cycle in advancing steps, measured from the ports.
  int hi_steps = 0, lo_steps = 0;
  bit meas = 0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (meas && (efr || eff)) begin
        if (sc) hi_steps++; else lo_steps++;
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1, 4'hF);
    for (int i = 0; i < 40; i++) step(0, 4'hF);
    // Each readiness input on its own, on a rise phase and a fall phase
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 3; k++) step(0, ~(4'b1 << b));
      step(0, 4'hF);
      for (int k = 0; k < 2; k++) step(0, ~(4'b1 << b));
      for (int k = 0; k < 5; k++) step(0, 4'hF);
    end
    // Hold just before a slow edge: run until next step would flip slow
    while (!(m_cnt == 0 && !m_fast)) step(0, 4'hF);
    for (int k = 0; k < 4; k++) step(0, 4'b1011);
    step(0, 4'hF);
    // Reset mid-sequence, then first edge after release
    for (int k = 0; k < 7; k++) step(0, 4'hF);
    step(1, 4'hF);
    step(1, 4'b0000);
    for (int k = 0; k < 20; k++) step(0, 4'hF);
    // Random holds
    for (int k = 0; k < 600; k++) begin
      logic [3:0] r;
      r = ($urandom_range(0, 2) == 0) ? 4'(~(4'b1 << $urandom_range(0, 3))) : 4'hF;
      step(0, r);
    end
    // Duty measurement over whole slow periods with random holds
    while (!(m_cnt == 0 && !m_fast && !m_slow)) step(0, 4'hF);
    @(negedge clk);
    meas = 1;
    rdy = 4'hF;
    q.push_back('{val: {1'b1, 1'b1, 1'b1, 4'b1010}, tag: "R4"});
    m_fast = 1; m_slow = 1; m_cnt = 1;
    for (int k = 0; k < 3 * 4 * HALF * 3; k++) begin
      if (m_cnt == 0 && !m_fast && !m_slow) break;
      step(0, ($urandom_range(0, 2) == 0) ? 4'b1101 : 4'hF);
    end
    @(negedge clk);
    meas = 0;
    check("R8", 7'(hi_steps), 7'(lo_steps));
    check("R8", 7'(hi_steps), 7'(2 * HALF * (hi_steps / (2 * HALF))));
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule